// File: doc/BRIEF.md
# Peripheral DMA Channel

This block is a single channel of a peripheral DMA controller. Software programs it through a small memory-mapped register file: a source address, a destination address and two control words. It then sets the channel enable bit, and a controller-wide master enable must also be set. The channel moves a programmed number of bursts. Each burst is a group of beats that are 1, 2 or 4 bytes wide. Each beat is offered on a valid/ready port as a source address, a destination address and a size code. A separate data path carries out the beat.

In demand mode, every burst waits for the peripheral request line that the channel selects. An acknowledge pulse marks the last beat of each burst. Software can pause and resume the channel without losing progress, or stop it by clearing the enable bit. The address registers advance as beats complete, so software can read them back to work out how much data has moved. When the last burst finishes, the channel clears its own enable bit and writes a nonzero stop code. The interrupt stays high until software writes zero into the stop field.

Top module: `pdma_channel`

## Requirements
- R1: After reset, every register reads zero, and `irq`, `xfer_valid` and `periph_ack` are low.
- R2: No beat is offered unless the master enable (bit 31 at offset 0x00) and the channel enable (bit 31 of the control word at 0x10) are both set.
- R3: A count field value N (bits 15:0 at 0x10) moves N+1 bursts. Burst code (bits 23:20 at 0x10) 0xB gives 4 beats per burst, 0xD gives 8 and 0xF gives 16. Any other code gives 1 beat.
- R4: Width code (bits 27:26 at 0x14) 0, 1 and 2 selects beats of 1, 2 and 4 bytes, and `xfer_size` carries the code. After each accepted beat, each address advances by the beat width. Bit 25 at 0x14 holds the source address fixed, and bit 24 holds the destination address fixed.
- R5: With mode (bits 29:28 at 0x14) equal to 2, each burst waits for `periph_req` on the line selected by bits 28:24 at 0x10. The other lines have no effect. `periph_ack` is high only in the cycle that the last beat of a burst is accepted.
- R6: While the pause bit (bit 30 at 0x10) is set, no beat is offered. Clearing it resumes the transfer with no beat lost or repeated.
- R7: Clearing the channel enable bit mid-transfer stops the channel. No further beats are offered.
- R8: After the final burst, the channel enable bit reads 0 and the stop field (bits 18:16 at 0x14) reads 3'b101. `irq` rises only if the completion interrupt enable (bit 19 at 0x14) is set.
- R9: Writing zero into the stop field drops `irq`.
- R10: Starting with width code 3 moves no data. The channel enable bit is cleared and the stop field reads 3'b001. `irq` rises if the error interrupt enable (bit 20 at 0x14) is set.
- R11: The source and destination registers (0x18 and 0x1C) read back the address of the next beat at any point in a transfer.
- R12: The register window is master control at 0x00, with only bit 31 implemented. The control words are at 0x10 and 0x14, the source address at 0x18 and the destination address at 0x1C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | RAW (8) | Register byte offset, used for both reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| periph_req | input | REQ_LINES (32) | Peripheral request lines |
| periph_ack | output | 1 | Acknowledge on the last beat of a demand-mode burst |
| xfer_valid | output | 1 | A beat is offered |
| xfer_ready | input | 1 | The data path accepts the beat |
| xfer_src | output | AW (32) | Source address of the beat |
| xfer_dst | output | AW (32) | Destination address of the beat |
| xfer_size | output | 2 | Beat width code |
| irq | output | 1 | Interrupt request |

## Verification
The hardest conditions to reach from the ports are a pause and an abort at a known beat boundary. The control word that holds the pause and enable bits also holds the live burst count, so software must read it and write it back while the count stands still. To do this, the stimulus stops accepting beats by holding `xfer_ready` low once a chosen number of beats has been accepted. It then rewrites the control word and releases the data path. Demand mode is reached by asserting a request line other than the selected one, and then by dropping the selected line right after the first burst's acknowledge. This shows that every burst waits for its own request.

// File: rtl/pdma_pkg.sv
package pdma_pkg;
  localparam logic [7:0] OFS_MASTER = 8'h00;
  localparam logic [7:0] OFS_CTRLA  = 8'h10;
  localparam logic [7:0] OFS_CTRLB  = 8'h14;
  localparam logic [7:0] OFS_SRC    = 8'h18;
  localparam logic [7:0] OFS_DST    = 8'h1C;

  localparam int A_EN    = 31;
  localparam int A_PAUSE = 30;
  localparam int A_SEL_LO = 24;
  localparam int A_BT_LO  = 20;
  localparam int CNT_W    = 16;

  localparam int B_MODE_LO  = 28;
  localparam int B_WID_LO   = 26;
  localparam int B_FIX_SRC  = 25;
  localparam int B_FIX_DST  = 24;
  localparam int B_ERR_IE   = 20;
  localparam int B_DONE_IE  = 19;
  localparam int B_STOP_LO  = 16;

  localparam logic [2:0] STOP_DONE = 3'b101;
  localparam logic [2:0] STOP_ERR  = 3'b001;
  localparam logic [1:0] MODE_DEMAND = 2'd2;

  typedef enum logic [1:0] {SQ_IDLE, SQ_WAIT, SQ_MOVE} seq_state_t;

  function automatic logic [3:0] last_beat_idx(input logic [3:0] code);
    case (code)
      4'hB:    return 4'd3;
      4'hD:    return 4'd7;
      4'hF:    return 4'd15;
      default: return 4'd0;
    endcase
  endfunction
endpackage

// File: rtl/pdma_regs.sv
module pdma_regs
  import pdma_pkg::*;
#(
  parameter int AW  = 32,
  parameter int RAW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wen,
  input  logic [RAW-1:0] addr,
  input  logic [31:0]    wdata,
  output logic [31:0]    rdata,
  input  logic           beat_step,
  input  logic           burst_step,
  input  logic           finish,
  input  logic           fail,
  output logic           master_en,
  output logic           chan_en,
  output logic           pause,
  output logic [4:0]     req_sel,
  output logic [3:0]     burst_code,
  output logic           cnt_zero,
  output logic [1:0]     mode,
  output logic [1:0]     wid_code,
  output logic [2:0]     stop,
  output logic           err_ie,
  output logic           done_ie,
  output logic [AW-1:0]  src,
  output logic [AW-1:0]  dst
);
  logic          mst_q, mst_d;
  logic [31:0]   ca_q, ca_d, cb_q, cb_d;
  logic [AW-1:0] src_q, src_d, dst_q, dst_d, step;
  logic          hit_mst, hit_ca, hit_cb, hit_src, hit_dst;

  assign hit_mst = wen && (addr == RAW'(OFS_MASTER));
  assign hit_ca  = wen && (addr == RAW'(OFS_CTRLA));
  assign hit_cb  = wen && (addr == RAW'(OFS_CTRLB));
  assign hit_src = wen && (addr == RAW'(OFS_SRC));
  assign hit_dst = wen && (addr == RAW'(OFS_DST));

  assign step = AW'(1) << cb_q[B_WID_LO +: 2];

  always_comb begin
    mst_d = mst_q;
    ca_d  = ca_q;
    cb_d  = cb_q;
    src_d = src_q;
    dst_d = dst_q;
    if (burst_step) ca_d[CNT_W-1:0] = ca_q[CNT_W-1:0] - CNT_W'(1);
    if (finish || fail) ca_d[A_EN] = 1'b0;
    if (finish) cb_d[B_STOP_LO +: 3] = STOP_DONE;
    if (fail)   cb_d[B_STOP_LO +: 3] = STOP_ERR;
    if (beat_step) begin
      if (!cb_q[B_FIX_SRC]) src_d = src_q + step;
      if (!cb_q[B_FIX_DST]) dst_d = dst_q + step;
    end
    if (hit_mst) mst_d = wdata[31];
    if (hit_ca)  ca_d  = wdata;
    if (hit_cb)  cb_d  = wdata;
    if (hit_src) src_d = wdata[AW-1:0];
    if (hit_dst) dst_d = wdata[AW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mst_q <= 1'b0;
      ca_q  <= '0;
      cb_q  <= '0;
      src_q <= '0;
      dst_q <= '0;
    end else begin
      mst_q <= mst_d;
      ca_q  <= ca_d;
      cb_q  <= cb_d;
      src_q <= src_d;
      dst_q <= dst_d;
    end
  end

  always_comb begin
    case (addr)
      RAW'(OFS_MASTER): rdata = {mst_q, 31'b0};
      RAW'(OFS_CTRLA):  rdata = ca_q;
      RAW'(OFS_CTRLB):  rdata = cb_q;
      RAW'(OFS_SRC):    rdata = 32'(src_q);
      RAW'(OFS_DST):    rdata = 32'(dst_q);
      default:          rdata = '0;
    endcase
  end

  assign master_en  = mst_q;
  assign chan_en    = ca_q[A_EN];
  assign pause      = ca_q[A_PAUSE];
  assign req_sel    = ca_q[A_SEL_LO +: 5];
  assign burst_code = ca_q[A_BT_LO +: 4];
  assign cnt_zero   = (ca_q[CNT_W-1:0] == '0);
  assign mode       = cb_q[B_MODE_LO +: 2];
  assign wid_code   = cb_q[B_WID_LO +: 2];
  assign stop       = cb_q[B_STOP_LO +: 3];
  assign err_ie     = cb_q[B_ERR_IE];
  assign done_ie    = cb_q[B_DONE_IE];
  assign src        = src_q;
  assign dst        = dst_q;
endmodule

// File: rtl/pdma_seq.sv
module pdma_seq
  import pdma_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       master_en,
  input  logic       chan_en,
  input  logic       pause,
  input  logic       demand,
  input  logic       req,
  input  logic [3:0] last_idx,
  input  logic       cnt_zero,
  input  logic       wid_bad,
  input  logic       ready,
  output logic       valid,
  output logic       beat_step,
  output logic       burst_step,
  output logic       finish,
  output logic       fail,
  output logic       ack
);
  seq_state_t st_q, st_d;
  logic [3:0] beat_q, beat_d;
  logic       run, hs, last, burst_end, beat_en;

  assign run       = master_en && chan_en;
  assign valid     = (st_q == SQ_MOVE) && run && !pause;
  assign hs        = valid && ready;
  assign last      = (beat_q == last_idx);
  assign burst_end = hs && last;
  assign beat_step = hs;
  assign ack       = burst_end && demand;
  assign finish    = burst_end && cnt_zero;
  assign burst_step = burst_end && !cnt_zero;
  assign fail      = (st_q == SQ_IDLE) && run && !pause && wid_bad;

  always_comb begin
    st_d    = st_q;
    beat_d  = beat_q;
    beat_en = 1'b0;
    if (!chan_en) begin
      st_d    = SQ_IDLE;
      beat_d  = '0;
      beat_en = 1'b1;
    end else if (!master_en) begin
      st_d = SQ_IDLE;
    end else begin
      case (st_q)
        SQ_IDLE: if (!pause && !wid_bad) st_d = demand ? SQ_WAIT : SQ_MOVE;
        SQ_WAIT: if (!pause && req) st_d = SQ_MOVE;
        SQ_MOVE: if (hs) begin
          beat_en = 1'b1;
          if (last) begin
            beat_d = '0;
            if (cnt_zero)    st_d = SQ_IDLE;
            else if (demand) st_d = SQ_WAIT;
          end else begin
            beat_d = beat_q + 4'd1;
          end
        end
        default: st_d = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      beat_q <= '0;
    end else begin
      st_q <= st_d;
      if (beat_en) beat_q <= beat_d;
    end
  end
endmodule

// File: rtl/pdma_channel.sv
module pdma_channel
  import pdma_pkg::*;
#(
  parameter int AW        = 32,
  parameter int RAW       = 8,
  parameter int REQ_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wen,
  input  logic [RAW-1:0]       reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic [REQ_LINES-1:0] periph_req,
  output logic                 periph_ack,
  output logic                 xfer_valid,
  input  logic                 xfer_ready,
  output logic [AW-1:0]        xfer_src,
  output logic [AW-1:0]        xfer_dst,
  output logic [1:0]           xfer_size,
  output logic                 irq
);
  logic [1:0]  rst_pipe;
  logic        rst_s_n;
  logic        master_en, chan_en, pause, cnt_zero, err_ie, done_ie;
  logic [4:0]  req_sel;
  logic [3:0]  burst_code;
  logic [1:0]  mode, wid_code;
  logic [2:0]  stop;
  logic        beat_step, burst_step, finish, fail;
  logic [31:0] req_wide;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  assign req_wide = 32'(periph_req);

  pdma_regs #(.AW(AW), .RAW(RAW)) u_regs (
    .clk(clk), .rst_n(rst_s_n), .wen(reg_wen), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .beat_step(beat_step),
    .burst_step(burst_step), .finish(finish), .fail(fail),
    .master_en(master_en), .chan_en(chan_en), .pause(pause),
    .req_sel(req_sel), .burst_code(burst_code), .cnt_zero(cnt_zero),
    .mode(mode), .wid_code(wid_code), .stop(stop), .err_ie(err_ie),
    .done_ie(done_ie), .src(xfer_src), .dst(xfer_dst)
  );

  pdma_seq u_seq (
    .clk(clk), .rst_n(rst_s_n), .master_en(master_en), .chan_en(chan_en),
    .pause(pause), .demand(mode == MODE_DEMAND), .req(req_wide[req_sel]),
    .last_idx(last_beat_idx(burst_code)), .cnt_zero(cnt_zero),
    .wid_bad(wid_code == 2'd3), .ready(xfer_ready), .valid(xfer_valid),
    .beat_step(beat_step), .burst_step(burst_step), .finish(finish),
    .fail(fail), .ack(periph_ack)
  );

  assign xfer_size = wid_code;
  assign irq = ((stop == STOP_DONE) && done_ie) || ((stop == STOP_ERR) && err_ie);
endmodule

// File: rtl/pdma_channel_chk.sv
module pdma_channel_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_s_n,
  input logic          reg_wen,
  input logic          xfer_valid,
  input logic          xfer_ready,
  input logic [AW-1:0] xfer_src,
  input logic          periph_ack,
  input logic          irq,
  input logic          master_en,
  input logic          chan_en,
  input logic          pause,
  input logic [2:0]    stop,
  input logic          finish
);
  AST_BEAT_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_s_n)
    xfer_valid |-> master_en && chan_en && !pause); // R2
  AST_ACK_ON_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_s_n)
    periph_ack |-> xfer_valid && xfer_ready); // R5
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_s_n)
    xfer_valid && !xfer_ready && !reg_wen |=> $stable(xfer_src)); // R4
  AST_IRQ_HAS_STATUS: assert property (@(posedge clk) disable iff (!rst_s_n)
    irq |-> stop != 3'b000); // R8
  AST_DONE_DROPS_EN: assert property (@(posedge clk) disable iff (!rst_s_n)
    finish && !reg_wen |=> !chan_en); // R8
endmodule

bind pdma_channel pdma_channel_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_s_n(rst_s_n), .reg_wen(reg_wen), .xfer_valid(xfer_valid),
  .xfer_ready(xfer_ready), .xfer_src(xfer_src), .periph_ack(periph_ack),
  .irq(irq), .master_en(master_en), .chan_en(chan_en), .pause(pause),
  .stop(stop), .finish(finish)
);

// File: tb/pdma_channel_test.sv
module pdma_channel_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_wen = 0;
  logic [7:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic [31:0] periph_req = 0;
  logic        periph_ack, xfer_valid, irq;
  logic        xfer_ready = 0;
  logic [31:0] xfer_src, xfer_dst;
  logic [1:0]  xfer_size;

  typedef struct packed {
    logic [31:0] s;
    logic [31:0] d;
    logic [1:0]  w;
    logic        a;
  } beat_t;

  beat_t expq[$];
  int n_chk = 0, n_fail = 0, seen = 0, acks = 0;
  bit hold = 0, stall = 0, done_flag = 0;

  always #5 clk = ~clk;

  pdma_channel uut (
    .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .periph_req(periph_req),
    .periph_ack(periph_ack), .xfer_valid(xfer_valid), .xfer_ready(xfer_ready),
    .xfer_src(xfer_src), .xfer_dst(xfer_dst), .xfer_size(xfer_size), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // ready generator
  initial forever begin
    @(posedge clk); #2;
    xfer_ready = hold ? 1'b0 : (stall ? 1'($urandom_range(0, 1)) : 1'b1);
  end

  // monitor: pops the scoreboard on each accepted beat
  always @(negedge clk) begin
    if (rst_n && xfer_valid && xfer_ready) begin
      if (expq.size() == 0) chk("R3 unexpected beat", xfer_src, 32'hx);
      else begin
        beat_t e;
        e = expq.pop_front();
        chk("R4 beat src", xfer_src, e.s);
        chk("R4 beat dst", xfer_dst, e.d);
        chk("R4 beat size", 32'(xfer_size), 32'(e.w));
        chk("R5 ack on burst end", 32'(periph_ack), 32'(e.a));
      end
      seen++;
    end
    if (periph_ack) acks++;
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #2;
    reg_wen = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #2;
    reg_wen = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(posedge clk); #2;
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic push_run(input logic [31:0] s0, input logic [31:0] d0, input logic [1:0] w,
                          input bit fs, input bit fd, input int beats, input int bursts,
                          input bit dem);
    logic [31:0] s = s0, d = d0;
    for (int b = 0; b < bursts; b++)
      for (int k = 0; k < beats; k++) begin
        beat_t e;
        e.s = s; e.d = d; e.w = w; e.a = dem && (k == beats - 1);
        expq.push_back(e);
        if (!fs) s += (32'd1 << w);
        if (!fd) d += (32'd1 << w);
      end
  endtask

  task automatic wait_done(input string tag);
    logic [31:0] v;
    for (int i = 0; i < 3000; i++) begin
      rd(8'h10, v);
      if (!v[31]) break;
    end
    chk({tag, " enable self-clears"}, 32'(v[31]), 32'd0);
    chk({tag, " scoreboard drained"}, expq.size(), 0);
  endtask

  function automatic logic [31:0] ctla(input bit en, input logic [4:0] sel,
                                       input logic [3:0] bt, input logic [15:0] cnt);
    return {en, 1'b0, 1'b0, sel, bt, 4'h0, cnt};
  endfunction

  function automatic logic [31:0] ctlb(input logic [1:0] mode, input logic [1:0] w, input bit fs,
                                       input bit fd, input bit ei, input bit ci);
    return {2'b00, mode, w, fs, fd, 3'b000, ei, ci, 3'b000, 16'h0};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    rd(8'h00, v); chk("R1 master reads 0", v, 0);
    rd(8'h10, v); chk("R1 ctrl A reads 0", v, 0);
    rd(8'h14, v); chk("R1 ctrl B reads 0", v, 0);
    rd(8'h18, v); chk("R1 src reads 0", v, 0);
    chk("R1 outputs idle", {29'd0, irq, xfer_valid, periph_ack}, 0);

    // R12 map, master only bit 31
    wr(8'h00, 32'h7FFF_FFFF); rd(8'h00, v); chk("R12 master unimplemented bits", v, 0);
    wr(8'h18, 32'h0000_1000); wr(8'h1C, 32'h0000_2000);
    rd(8'h18, v); chk("R12 src offset", v, 32'h1000);
    rd(8'h1C, v); chk("R12 dst offset", v, 32'h2000);
    wr(8'h14, ctlb(0, 2, 0, 0, 0, 1));
    rd(8'h14, v); chk("R12 ctrl B offset", v, ctlb(0, 2, 0, 0, 0, 1));
    // R2 gate by master enable
    wr(8'h10, ctla(1, 0, 4'hB, 1));
    base = seen;
    repeat (10) @(negedge clk);
    chk("R2 no beat without master enable", seen - base, 0);
    push_run(32'h1000, 32'h2000, 2, 0, 0, 4, 2, 0);
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, v); chk("R12 master bit 31", v, 32'h8000_0000);
    wait_done("R3 burst code B count 1");
    rd(8'h14, v); chk("R8 stop code done", 32'(v[18:16]), 32'd5);
    @(negedge clk); chk("R8 irq with completion enable", 32'(irq), 1);
    wr(8'h14, ctlb(0, 2, 0, 0, 0, 1));
    @(negedge clk); chk("R9 irq cleared by zero stop field", 32'(irq), 0);

    // 1-byte single beats, fixed dst, no interrupt enable, stalls
    stall = 1;
    wr(8'h18, 32'h100); wr(8'h1C, 32'h4000_0000);
    wr(8'h14, ctlb(0, 0, 0, 1, 0, 0));
    push_run(32'h100, 32'h4000_0000, 0, 0, 1, 1, 5, 0);
    wr(8'h10, ctla(1, 0, 4'h3, 4));
    wait_done("R3 single beats count 4");
    rd(8'h14, v); chk("R8 stop done no irq enable", 32'(v[18:16]), 32'd5);
    chk("R8 irq low when disabled", 32'(irq), 0);

    // 2-byte, 8-beat burst, fixed src
    wr(8'h18, 32'h2000_0000); wr(8'h1C, 32'h300);
    wr(8'h14, ctlb(0, 1, 1, 0, 0, 1));
    push_run(32'h2000_0000, 32'h300, 1, 1, 0, 8, 1, 0);
    wr(8'h10, ctla(1, 0, 4'hD, 0));
    wait_done("R3 burst code D");

    // 4-byte, 16-beat burst
    stall = 0;
    wr(8'h18, 32'h800); wr(8'h1C, 32'h900);
    wr(8'h14, ctlb(0, 2, 0, 0, 0, 0));
    push_run(32'h800, 32'h900, 2, 0, 0, 16, 1, 0);
    wr(8'h10, ctla(1, 0, 4'hF, 0));
    wait_done("R3 burst code F");

    // R5 demand mode on line 5, line 3 is a distractor
    wr(8'h18, 32'hA00); wr(8'h1C, 32'hB00);
    wr(8'h14, ctlb(2, 2, 0, 0, 0, 0));
    push_run(32'hA00, 32'hB00, 2, 0, 0, 4, 3, 1);
    periph_req[3] = 1;
    base = seen; acks = 0;
    wr(8'h10, ctla(1, 5, 4'hB, 2));
    repeat (20) @(negedge clk);
    chk("R5 other request line ignored", seen - base, 0);
    periph_req[5] = 1;
    wait (acks == 1);
    @(posedge clk); #1; periph_req[5] = 0;
    base = seen;
    repeat (15) @(negedge clk);
    chk("R5 next burst waits for request", seen - base, 0);
    periph_req[5] = 1;
    wait_done("R5 demand three bursts");
    chk("R5 one ack per burst", acks, 3);
    periph_req = 0;

    // R6 pause and resume
    wr(8'h18, 32'hC00); wr(8'h1C, 32'hD00);
    wr(8'h14, ctlb(0, 2, 0, 0, 0, 0));
    push_run(32'hC00, 32'hD00, 2, 0, 0, 1, 10, 0);
    base = seen;
    wr(8'h10, ctla(1, 0, 4'h0, 9));
    wait (seen == base + 3);
    @(posedge clk); #1; hold = 1; xfer_ready = 0;
    rd(8'h10, v); wr(8'h10, v | 32'h4000_0000);
    hold = 0;
    base = seen;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (xfer_valid) chk("R6 valid while paused", 1, 0);
    end
    chk("R6 no beats while paused", seen - base, 0);
    rd(8'h10, v); wr(8'h10, v & ~32'h4000_0000);
    wait_done("R6 resume completes");

    // R7 abort and R11 address readback
    wr(8'h18, 32'h3000); wr(8'h1C, 32'h5000);
    wr(8'h14, ctlb(0, 1, 0, 0, 0, 1));
    push_run(32'h3000, 32'h5000, 1, 0, 0, 1, 10, 0);
    base = seen;
    wr(8'h10, ctla(1, 0, 4'h0, 9));
    wait (seen == base + 4);
    @(posedge clk); #1; hold = 1; xfer_ready = 0;
    rd(8'h10, v); wr(8'h10, v & ~32'h8000_0000);
    hold = 0;
    base = seen;
    repeat (12) @(negedge clk);
    chk("R7 no beats after disable", seen - base, 0);
    rd(8'h18, v); chk("R11 src after 4 beats", v, 32'h3008);
    rd(8'h1C, v); chk("R11 dst after 4 beats", v, 32'h5008);
    rd(8'h14, v); chk("R7 abort leaves stop clear", 32'(v[18:16]), 0);
    expq.delete();

    // R10 invalid width
    wr(8'h14, ctlb(0, 3, 0, 0, 1, 0));
    base = seen;
    wr(8'h10, ctla(1, 0, 4'h0, 3));
    repeat (5) @(negedge clk);
    chk("R10 no beats with bad width", seen - base, 0);
    rd(8'h10, v); chk("R10 enable cleared", 32'(v[31]), 0);
    rd(8'h14, v); chk("R10 stop code error", 32'(v[18:16]), 1);
    chk("R10 irq with error enable", 32'(irq), 1);
    wr(8'h14, 32'h0);
    @(negedge clk); chk("R9 error irq cleared", 32'(irq), 0);

    finish_run();
  end
endmodule